// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It reads three levels of translation tables held in memory. A request carries the virtual address and a 32-bit root register that locates a four-entry top table. The walker then issues 64-bit entry reads, one at a time, on a request/response memory port. It reads the top-table entry first, then the directory entry, then the page-table entry.

Each entry supplies a 24-bit frame number, and the next table sits at that frame shifted left by twelve. The walk ends with a one-cycle completion pulse. With it comes either the physical address (last frame joined to the 12-bit offset) or a fault flag and the number of the level whose entry was not present.

The walker is meant to sit behind a translation cache and run only on misses. One walk is in flight at a time, and a new request is taken only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: The virtual address splits into top index [31:30], directory index [29:21], table index [20:12] and offset [11:0]. A successful walk returns `paddr` = {last-level frame, offset}.
- R2: The top-table entry address is {root[31:5], 5'b0} + top index × 8. Root bits [4:0] have no effect, and this address always has bits [35:32] zero.
- R3: The directory entry address is (top-entry frame << 12) + directory index × 8. The page-table entry address is (directory-entry frame << 12) + table index × 8.
- R4: A successful walk makes exactly three reads: top table, then directory, then page table.
- R5: The frame number is entry bits [35:12]. Entry bits [63:36] and [11:1] have no effect.
- R6: Entry bit 0 is the present flag. If it is clear, the walk ends with `fault`=1, `fault_level` set to 1 (top), 2 (directory) or 3 (page table), `paddr`=0, and no further reads.
- R7: Only one read is outstanding. `mem_req_valid` and `mem_req_addr` stay steady until `mem_req_ready`. The next read is issued only after `mem_rsp_valid` returns the previous entry.
- R8: `req_ready` is high only when idle. A `req_valid` during a walk is ignored and does not change that walk's result.
- R9: `done` is high for exactly one cycle per walk. `paddr`, `fault` and `fault_level` change only in that cycle and hold until the next completion.
- R10: After reset, `req_ready`=1 and `mem_req_valid`=0, `done`=0, `fault`=0, `paddr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Root register locating the top table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended on a non-present entry |
| fault_level | output | 2 | Failing level (1..3), 0 on success |
| paddr | output | 36 | Translated physical address |

## Verification
Successful walks use addresses that select each of the four top-table slots, including the all-ones virtual address with all-ones frames. This shows that each index lands in its own field and that no carry crosses field boundaries. A run with junk in the root's low bits and in the unused entry bits separates the real frame bits from the ignored ones. Walks with the present flag cleared at each of the three levels tell the fault levels apart and confirm that the walker stops reading. A run where the memory holds off acceptance, while another request is pushed at the busy walker, tests the handshake hold and the rejection of requests during a walk.

// File: rtl/walker_pkg.sv
// Shared definitions for the page table walker.
// Assumes three translation levels; the state order follows the walk order.
package walker_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_L1   = 3'd1,
        ST_L2   = 3'd2,
        ST_L3   = 3'd3,
        ST_END  = 3'd4
    } walk_state_t;

    localparam int unsigned ENT_BYTES_LOG2 = 3;
endpackage

// File: rtl/walk_index_split.sv
// Splits a virtual address into the top index, directory index, table index
// and page offset. Assumes VA_W == TOP_W + 2*IDX_W + OFF_W.
module walk_index_split #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned TOP_W = 2,
    parameter int unsigned IDX_W = 9,
    parameter int unsigned OFF_W = 12
) (
    input  logic [VA_W-1:0]  vaddr,
    output logic [TOP_W-1:0] top_idx,
    output logic [IDX_W-1:0] dir_idx,
    output logic [IDX_W-1:0] tbl_idx,
    output logic [OFF_W-1:0] offset
);
    localparam int unsigned TBL_LO = OFF_W;
    localparam int unsigned DIR_LO = OFF_W + IDX_W;
    localparam int unsigned TOP_LO = OFF_W + 2 * IDX_W;

    // Slice the address into its fixed fields.
    always_comb begin
        offset  = vaddr[OFF_W-1:0];
        tbl_idx = vaddr[TBL_LO +: IDX_W];
        dir_idx = vaddr[DIR_LO +: IDX_W];
        top_idx = vaddr[TOP_LO +: TOP_W];
    end
endmodule

// File: rtl/walk_entry_addr.sv
// Forms the byte address of the entry read at the current level:
// table base plus index times the entry size. Level 1 takes its base from
// the root register with its low ROOT_ALIGN bits forced to zero. Levels 2 and 3
// use the frame-derived base supplied by the controller.
module walk_entry_addr #(
    parameter int unsigned PA_W       = 36,
    parameter int unsigned ROOT_W     = 32,
    parameter int unsigned ROOT_ALIGN = 5,
    parameter int unsigned TOP_W      = 2,
    parameter int unsigned IDX_W      = 9
) (
    input  logic [1:0]        level,
    input  logic [ROOT_W-1:0] root,
    input  logic [PA_W-1:0]   next_base,
    input  logic [TOP_W-1:0]  top_idx,
    input  logic [IDX_W-1:0]  dir_idx,
    input  logic [IDX_W-1:0]  tbl_idx,
    output logic [PA_W-1:0]   entry_addr
);
    import walker_pkg::*;

    logic [PA_W-1:0]  root_base;
    logic [PA_W-1:0]  base_sel;
    logic [IDX_W-1:0] idx_sel;

    // Aligned top-table base taken from the root register.
    assign root_base = {{(PA_W-ROOT_W){1'b0}}, root[ROOT_W-1:ROOT_ALIGN], {ROOT_ALIGN{1'b0}}};

    // Choose base and index for the level being read.
    always_comb begin
        case (level)
            2'd1:    begin base_sel = root_base; idx_sel = {{(IDX_W-TOP_W){1'b0}}, top_idx}; end
            2'd2:    begin base_sel = next_base; idx_sel = dir_idx; end
            default: begin base_sel = next_base; idx_sel = tbl_idx; end
        endcase
    end

    // Base plus scaled index.
    assign entry_addr = base_sel + ({{(PA_W-IDX_W){1'b0}}, idx_sel} << ENT_BYTES_LOG2);
endmodule

// File: rtl/walk_ctrl.sv
// Sequences the walk: accepts a request when idle, issues one entry read per
// level with a valid/ready handshake, waits for the response, checks the
// present bit and either advances, finishes or faults. Results are held
// in registers until the next completion.
module walk_ctrl #(
    parameter int unsigned PA_W    = 36,
    parameter int unsigned ENT_W   = 64,
    parameter int unsigned FRAME_W = 24,
    parameter int unsigned OFF_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    output logic             accept,
    output logic [1:0]       level,
    output logic [PA_W-1:0]  next_base,
    input  logic [OFF_W-1:0] offset,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_data,
    output logic             done,
    output logic             fault,
    output logic [1:0]       fault_level,
    output logic [PA_W-1:0]  paddr
);
    import walker_pkg::*;

    walk_state_t          state_q;
    logic                 issued_q;
    logic [PA_W-1:0]      base_q;
    logic [PA_W-1:0]      paddr_q;
    logic                 fault_q;
    logic [1:0]           flvl_q;
    logic                 walking;
    logic                 present;
    logic [FRAME_W-1:0]   frame;

    // Decode the current state into handshake and level signals.
    always_comb begin
        walking = (state_q == ST_L1) || (state_q == ST_L2) || (state_q == ST_L3);
        case (state_q)
            ST_L1:   level = 2'd1;
            ST_L2:   level = 2'd2;
            ST_L3:   level = 2'd3;
            default: level = 2'd0;
        endcase
    end

    assign present       = mem_rsp_data[0];
    assign frame         = mem_rsp_data[OFF_W +: FRAME_W];
    assign req_ready     = (state_q == ST_IDLE);
    assign accept        = req_ready && req_valid;
    assign mem_req_valid = walking && !issued_q;
    assign next_base     = base_q;
    assign done          = (state_q == ST_END);
    assign fault         = fault_q;
    assign fault_level   = flvl_q;
    assign paddr         = paddr_q;

    // Walk state machine with result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            issued_q <= 1'b0;
            base_q   <= '0;
            paddr_q  <= '0;
            fault_q  <= 1'b0;
            flvl_q   <= 2'd0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q  <= ST_L1;
                        issued_q <= 1'b0;
                    end
                end
                ST_L1, ST_L2, ST_L3: begin
                    if (!issued_q) begin
                        if (mem_req_ready) issued_q <= 1'b1;
                    end else if (mem_rsp_valid) begin
                        issued_q <= 1'b0;
                        if (!present) begin
                            fault_q <= 1'b1;
                            flvl_q  <= level;
                            paddr_q <= '0;
                            state_q <= ST_END;
                        end else if (state_q == ST_L3) begin
                            fault_q <= 1'b0;
                            flvl_q  <= 2'd0;
                            paddr_q <= {frame, offset};
                            state_q <= ST_END;
                        end else begin
                            base_q  <= {frame, {OFF_W{1'b0}}};
                            state_q <= (state_q == ST_L1) ? ST_L2 : ST_L3;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R9: completion lasts one cycle.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: results move only in the completion cycle.
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(paddr) && $stable(fault) && $stable(fault_level)) |-> done);
    // R8: no new request is taken while a read is pending.
    assert_idle_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);
    // R6: a fault always names its level.
    assert_fault_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (fault_level != 2'd0));
    // R7: a request not yet accepted stays raised.
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid);
endmodule

// File: rtl/pt_walker.sv
// Three-level page table walker top. Captures the request, splits the
// virtual address, forms entry addresses and runs the walk controller.
// Assumes the memory answers each accepted read with exactly one response.
module pt_walker #(
    parameter int unsigned VA_W       = 32,
    parameter int unsigned ROOT_W     = 32,
    parameter int unsigned ROOT_ALIGN = 5,
    parameter int unsigned TOP_W      = 2,
    parameter int unsigned IDX_W      = 9,
    parameter int unsigned OFF_W      = 12,
    parameter int unsigned FRAME_W    = 24,
    parameter int unsigned ENT_W      = 64,
    parameter int unsigned PA_W       = FRAME_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [ROOT_W-1:0] req_root,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_level,
    output logic [PA_W-1:0]   paddr
);
    logic [VA_W-1:0]   va_q;
    logic [ROOT_W-1:0] root_q;
    logic              accept;
    logic [1:0]        level;
    logic [PA_W-1:0]   next_base;
    logic [TOP_W-1:0]  top_idx;
    logic [IDX_W-1:0]  dir_idx;
    logic [IDX_W-1:0]  tbl_idx;
    logic [OFF_W-1:0]  offset;

    // Capture the request operands when the walker accepts them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            root_q <= '0;
        end else if (accept) begin
            va_q   <= req_vaddr;
            root_q <= req_root;
        end
    end

    walk_index_split #(.VA_W(VA_W), .TOP_W(TOP_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
        .vaddr(va_q), .top_idx(top_idx), .dir_idx(dir_idx), .tbl_idx(tbl_idx), .offset(offset)
    );

    walk_entry_addr #(.PA_W(PA_W), .ROOT_W(ROOT_W), .ROOT_ALIGN(ROOT_ALIGN),
                      .TOP_W(TOP_W), .IDX_W(IDX_W)) u_addr (
        .level(level), .root(root_q), .next_base(next_base), .top_idx(top_idx),
        .dir_idx(dir_idx), .tbl_idx(tbl_idx), .entry_addr(mem_req_addr)
    );

    walk_ctrl #(.PA_W(PA_W), .ENT_W(ENT_W), .FRAME_W(FRAME_W), .OFF_W(OFF_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .accept(accept), .level(level), .next_base(next_base), .offset(offset),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .fault_level(fault_level), .paddr(paddr)
    );

    // R7: a stalled read keeps its address.
    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));
    // R2: top-table reads stay inside the root register's reach.
    assert_top_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && level == 2'd1) |-> (mem_req_addr[PA_W-1:ROOT_W] == '0));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_root = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [35:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic        fault;
    logic [1:0]  fault_level;
    logic [35:0] paddr;

    int total = 0;
    int bad = 0;

    logic [63:0] mem [logic [35:0]];
    logic [35:0] exp_a [3];
    logic [35:0] seen [8];
    int          n_seen;

    always #2 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
        .fault(fault), .fault_level(fault_level), .paddr(paddr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Fill the three entries a walk of va under root will read.
    task automatic build(input [31:0] va, input [31:0] root, input [23:0] f1, input [23:0] f2,
                         input [23:0] f3, input [2:0] pres, input [63:0] junk);
        mem.delete();
        exp_a[0] = {4'h0, root[31:5], 5'b0} + {31'b0, va[31:30], 3'b0};
        exp_a[1] = {f1, 12'b0} + {24'b0, va[29:21], 3'b0};
        exp_a[2] = {f2, 12'b0} + {24'b0, va[20:12], 3'b0};
        mem[exp_a[0]] = {junk[63:36], f1, junk[11:1], pres[0]};
        mem[exp_a[1]] = {junk[63:36], f2, junk[11:1], pres[1]};
        mem[exp_a[2]] = {junk[63:36], f3, junk[11:1], pres[2]};
    endtask

    // Run one walk acting as the memory; stall holds ready low per read.
    task automatic walk(input [31:0] va, input [31:0] root, input int stall, input bit poke,
                        output bit got, output bit flt, output [1:0] lvl, output [35:0] pa);
        bit          pending = 0;
        logic [35:0] pend_addr = '0;
        logic [35:0] first_addr = '0;
        int          stall_cnt = 0;
        got = 0; flt = 0; lvl = 0; pa = '0; n_seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_root = root;
        for (int cyc = 0; cyc < 80 && !got; cyc++) begin
            @(negedge clk);
            req_valid = 1'b0; mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
            if (done) begin
                got = 1; flt = fault; lvl = fault_level; pa = paddr;
            end else if (pending) begin
                check(!mem_req_valid, "R7 read while one outstanding", {63'b0, mem_req_valid}, 64'h0);
                mem_rsp_valid = 1'b1;
                mem_rsp_data = mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
                pending = 0;
            end else if (mem_req_valid) begin
                if (stall_cnt == 0) first_addr = mem_req_addr;
                else check(mem_req_addr == first_addr, "R7 address held in stall",
                           {28'b0, mem_req_addr}, {28'b0, first_addr});
                if (stall_cnt < stall) begin
                    stall_cnt++;
                    if (poke) begin
                        check(!req_ready, "R8 busy walker not ready", {63'b0, req_ready}, 64'h0);
                        req_valid = 1'b1; req_vaddr = ~va; req_root = ~root;
                    end
                end else begin
                    mem_req_ready = 1'b1;
                    if (n_seen < 8) seen[n_seen] = mem_req_addr;
                    n_seen++;
                    pending = 1; pend_addr = mem_req_addr; stall_cnt = 0;
                end
            end
        end
    endtask

    // Successful walk with full checks on addresses and result.
    task automatic run_ok(input string name, input [31:0] va, input [31:0] root, input [23:0] f1,
                          input [23:0] f2, input [23:0] f3, input [63:0] junk, input int stall, input bit poke);
        bit got, flt; logic [1:0] lvl; logic [35:0] pa;
        build(va, root, f1, f2, f3, 3'b111, junk);
        walk(va, root, stall, poke, got, flt, lvl, pa);
        check(got, {"R9 completion ", name}, {63'b0, got}, 64'h1);
        check(n_seen == 3, {"R4 three reads ", name}, n_seen, 3);
        check(seen[0] == exp_a[0], {"R2 top entry address ", name}, {28'b0, seen[0]}, {28'b0, exp_a[0]});
        check(seen[1] == exp_a[1], {"R3 directory entry address ", name}, {28'b0, seen[1]}, {28'b0, exp_a[1]});
        check(seen[2] == exp_a[2], {"R3 table entry address ", name}, {28'b0, seen[2]}, {28'b0, exp_a[2]});
        check(!flt && lvl == 0, {"R6 no fault ", name}, {61'b0, flt, lvl}, 64'h0);
        check(pa == {f3, va[11:0]}, {"R1 R5 physical address ", name}, {28'b0, pa}, {28'b0, f3, va[11:0]});
        @(negedge clk);
        check(!done, {"R9 done one cycle ", name}, {63'b0, done}, 64'h0);
        check(paddr == pa, {"R9 result held ", name}, {28'b0, paddr}, {28'b0, pa});
    endtask

    // Walk that must fault at the given level.
    task automatic run_fault(input int level);
        bit got, flt; logic [1:0] lvl; logic [35:0] pa;
        logic [2:0] pres;
        pres = (level == 1) ? 3'b110 : (level == 2) ? 3'b101 : 3'b011;
        build(32'h8765_4321, 32'h0002_0000, 24'h000100, 24'h000200, 24'h000300, pres, 64'h0);
        walk(32'h8765_4321, 32'h0002_0000, 0, 0, got, flt, lvl, pa);
        check(got && flt, "R6 fault raised", {62'b0, got, flt}, 64'h3);
        check(lvl == level[1:0], "R6 fault level", {62'b0, lvl}, level);
        check(n_seen == level, "R6 reads stop at failing level", n_seen, level);
        check(pa == '0, "R6 paddr cleared on fault", {28'b0, pa}, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R4 watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset values
        check(req_ready && !mem_req_valid && !done && !fault && paddr == 0, "R10 reset state",
              {59'b0, req_ready, mem_req_valid, done, fault, |paddr}, 64'h10);
        rst_n = 1'b1;
        @(negedge clk);
        run_ok("basic", 32'h4123_4567, 32'h0000_1000, 24'h000010, 24'h000020, 24'h0ABCDE, 64'h0, 0, 0);
        run_ok("root low bits", 32'h0000_0FFF, 32'h1234_567F, 24'h111111, 24'h222222, 24'h333333, 64'h0, 0, 0);
        run_ok("all ones", 32'hFFFF_FFFF, 32'hFFFF_FFE0, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF,
               64'hFFFF_FFF0_0000_0FFE, 0, 0);
        run_ok("junk bits", 32'hBFE0_1ABC, 32'h0000_4000, 24'h800001, 24'h7FFFF0, 24'h5A5A5A,
               64'hDEAD_BEE0_0000_0AAA, 0, 0);
        run_ok("stall poke", 32'h6ABC_D123, 32'h0008_0020, 24'h000555, 24'h000666, 24'h000777, 64'h0, 3, 1);
        run_fault(1);
        run_fault(2);
        run_fault(3);
        run_ok("after fault", 32'h0040_2008, 32'h0000_0040, 24'h00000A, 24'h00000B, 24'h00000C, 64'h0, 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule